// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block collects transfer requests from four peripherals and decides which one is served next. The request lines are asynchronous, so each one is synchronised before it takes part in arbitration. When an enabled channel has a request pending, the block asks the processor for the bus with a hold request. It waits for the hold acknowledge, then grants one transfer cycle to the winning channel by pulling that channel's active-low acknowledge low for a single clock.

Each channel keeps a transfer counter that software loads with N. The channel then performs N+1 transfers. A terminal-count output marks the last of these, and a mark output flags every 128th transfer. When a channel reaches terminal count, its enable is cleared and a sticky flag is set in the status word. That flag stays set until the status word is read.

A write-only mode word enables the channels and chooses between fixed and rotating priority. Once no enabled request remains, the hold request is released and the block returns to idle.

Top module: `dma_req_ctrl`

## Requirements
- R1: Each request input passes through two flip-flops before it is used. A level applied to `dreq_i[n]` appears in `status_o[4+n]` after the second rising clock edge and not after the first.
- R2: `hold_req_o` rises while an enabled channel has a synchronised request. No acknowledge goes low while `hold_ack_i` is 0.
- R3: The acknowledges `dack_no` are active low and at most one is low in any cycle. Each transfer holds one acknowledge low for exactly one clock. After reset all acknowledges are high, and `hold_req_o`, `tc_o`, `mark_o` and `status_o` are 0.
- R4: In fixed mode (mode bit 4 = 0), channel 0 has the highest priority and channel 3 the lowest. The mode is re-evaluated before every transfer.
- R5: In rotating mode (mode bit 4 = 1), the channel just served becomes the lowest priority and the next channel in index order becomes the highest. After reset, channel 0 leads.
- R6: Mode word bits 3:0 enable channels 3..0 (written with `wr_sel_i` = 4). A request on a disabled channel is ignored and does not raise `hold_req_o`.
- R7: Writing N to the count of channel n (`wr_sel_i` = n, bits 13:0) gives N+1 transfers. `tc_o` is high only during the last of these, and that transfer clears the channel's enable.
- R8: `mark_o` is high during every 128th transfer of a channel, counted from the last count load.
- R9: Reaching terminal count sets `status_o[n]`. The bit stays set until a cycle with `stat_rd_i` high, after which it reads 0.
- R10: `hold_req_o` drops once no enabled channel has a pending request, and the block goes back to sampling requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dreq_i | input | 4 | Asynchronous channel requests |
| hold_ack_i | input | 1 | Bus granted by the processor |
| hold_req_o | output | 1 | Bus request to the processor |
| dack_no | output | 4 | Per-channel acknowledge, active low |
| tc_o | output | 1 | Terminal-count transfer |
| mark_o | output | 1 | Every 128th transfer |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | 0..3 channel count, 4 mode word |
| wr_data_i | input | 16 | Write data |
| stat_rd_i | input | 1 | Status read, clears the terminal-count flags |
| status_o | output | 8 | [7:4] synchronised requests, [3:0] terminal-count flags |

## Verification
The assertions check on every cycle that at most one acknowledge is low, and that an acknowledge follows a sampled hold acknowledge. They also check that terminal count and mark only appear inside a transfer, that channel 0 always wins in fixed mode when it is requesting, that terminal-count flags persist until read, and that the counters step by one. Only the bench scenarios can show the full service orders in fixed and rotating mode, the exact number of transfers for a loaded count, where mark lands in a long run, the two-stage synchroniser latency, and the release of the bus after the last enabled channel finishes.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_XFER} dma_state_e;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             rot_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  always_comb begin
    int start;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    start = 0;
    if (rot_i) start = (int'(last_i) == N - 1) ? 0 : int'(last_i) + 1;
    for (int i = 0; i < N; i++) begin
      int k;
      k = start + i;
      if (k >= N) k = k - N;
      if (!gnt_valid_o && req_i[k]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(k);
      end
    end
  end

  // R4
  fixed_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rot_i && req_i[0]) |-> (gnt_valid_o && gnt_idx_o == '0));
  // R4
  gnt_is_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> req_i[gnt_idx_o]);
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int CNT_W       = 14,
  parameter int MARK_PERIOD = 128,
  localparam int MARK_W     = $clog2(MARK_PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             xfer_i,
  input  logic             clr_flag_i,
  output logic             tc_o,
  output logic             mark_o,
  output logic             flag_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [MARK_W-1:0] mcnt_q;
  logic              flag_q;

  assign tc_o   = (cnt_q == '0);
  assign mark_o = (mcnt_q == MARK_W'(MARK_PERIOD - 1));
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mcnt_q <= '0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      mcnt_q <= '0;
    end else if (xfer_i) begin
      if (!tc_o) cnt_q <= cnt_q - 1'b1;
      mcnt_q <= mark_o ? '0 : mcnt_q + 1'b1;
    end
  end

  // set wins over a simultaneous read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (xfer_i && tc_o)    flag_q <= 1'b1;
    else if (clr_flag_i)        flag_q <= 1'b0;
  end

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_flag_i) |=> flag_q);
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int CNT_W       = 14,
  parameter int MARK_PERIOD = 128,
  parameter int DATA_W      = 16,
  localparam int IDX_W      = $clog2(N_CH),
  localparam int SEL_W      = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   dreq_i,
  input  logic              hold_ack_i,
  output logic              hold_req_o,
  output logic [N_CH-1:0]   dack_no,
  output logic              tc_o,
  output logic              mark_o,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic [2*N_CH-1:0] status_o
);
  dma_state_e       state_q;
  logic [N_CH-1:0]  req_s, en_q, pend_vec, ch_tc, ch_mark, ch_flag, ch_xfer;
  logic             rot_q, pend, xfer, gnt_valid, mode_wr;
  logic [IDX_W-1:0] grant_q, last_q, gnt_idx;

  dma_sync #(.W(N_CH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dreq_i), .q_o(req_s)
  );

  assign pend_vec = req_s & en_q;
  assign pend     = |pend_vec;
  assign xfer     = (state_q == ST_XFER);
  assign mode_wr  = wr_en_i && (wr_sel_i == SEL_W'(N_CH));

  dma_arb #(.N(N_CH), .IDX_W(IDX_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(pend_vec), .rot_i(rot_q),
    .last_i(last_q), .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_xfer[g] = xfer && (grant_q == IDX_W'(g));
    assign dack_no[g] = ~ch_xfer[g];
    dma_chan #(.CNT_W(CNT_W), .MARK_PERIOD(MARK_PERIOD)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(wr_en_i && (wr_sel_i == SEL_W'(g))),
      .load_val_i(wr_data_i[CNT_W-1:0]),
      .xfer_i(ch_xfer[g]), .clr_flag_i(stat_rd_i),
      .tc_o(ch_tc[g]), .mark_o(ch_mark[g]), .flag_o(ch_flag[g])
    );
  end

  assign tc_o       = xfer && ch_tc[grant_q];
  assign mark_o     = xfer && ch_mark[grant_q];
  assign hold_req_o = (state_q != ST_IDLE);
  assign status_o   = {req_s, ch_flag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rot_q <= 1'b0;
    end else if (mode_wr) begin
      en_q  <= wr_data_i[N_CH-1:0];
      rot_q <= wr_data_i[N_CH];
    end else if (tc_o) begin
      en_q[grant_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      last_q  <= IDX_W'(N_CH - 1);
    end else begin
      case (state_q)
        ST_IDLE: if (pend) state_q <= ST_REQ;
        ST_REQ: begin
          if (!pend) state_q <= ST_IDLE;
          else if (hold_ack_i && gnt_valid) begin
            state_q <= ST_XFER;
            grant_q <= gnt_idx;
          end
        end
        ST_XFER: begin
          state_q <= ST_REQ;
          last_q  <= grant_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  dack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));
  // R3
  dack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) |=> (dack_no == '1));
  // R2
  dack_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) |-> ($past(hold_ack_i) && hold_req_o));
  // R7
  tc_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (dack_no != '1));
  // R8
  mark_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> (dack_no != '1));
endmodule

// File: tb/dma_req_ctrl_test.sv
module dma_req_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dreq = '0;
  logic       hold_ack = 1'b0;
  logic       hold_req;
  logic [3:0] dack_n;
  logic       tc, mark;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic       stat_rd = 1'b0;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  int log_n = 0;
  int log_ch [0:255];
  bit log_tc [0:255];
  bit log_mk [0:255];

  always #2 clk = ~clk;

  dma_req_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .hold_ack_i(hold_ack),
    .hold_req_o(hold_req), .dack_no(dack_n), .tc_o(tc), .mark_o(mark),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .stat_rd_i(stat_rd), .status_o(status)
  );

  always @(negedge clk) begin
    if (rst_n && dack_n !== 4'hf && log_n < 256) begin
      for (int i = 0; i < 4; i++) if (!dack_n[i]) log_ch[log_n] = i;
      log_tc[log_n] = tc;
      log_mk[log_n] = mark;
      log_n = log_n + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(int sel, int data);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic wait_log(int n);
    int k = 0;
    while (log_n < n && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_idle();
    int k = 0;
    while (hold_req && k < 3000) begin @(negedge clk); k++; end
    cycles(2);
  endtask

  task automatic t_reset();
    cycles(2);
    check("R3 reset hold_req", hold_req, 0);
    check("R3 reset dack", dack_n, 15);
    check("R3 reset tc", tc, 0);
    check("R3 reset mark", mark, 0);
    check("R3 reset status", status, 0);
  endtask

  task automatic t_sync();
    dreq = 4'b0100;
    @(negedge clk);
    check("R1 one edge", status[6], 0);
    @(negedge clk);
    check("R1 two edges", status[6], 1);
    cycles(5);
    check("R6 disabled ignored", hold_req, 0);
    dreq = '0;
    cycles(3);
  endtask

  task automatic t_hold_count();
    write_reg(1, 2);
    write_reg(4, 16'h0002);
    log_n = 0;
    dreq = 4'b0010;
    cycles(8);
    check("R2 hold_req raised", hold_req, 1);
    check("R2 no dack without ack", log_n, 0);
    hold_ack = 1'b1;
    wait_log(3);
    cycles(10);
    check("R7 transfers for N=2", log_n, 3);
    for (int i = 0; i < 3; i++) begin
      check("R3 channel served", log_ch[i], 1);
      check("R7 tc on last only", log_tc[i], (i == 2) ? 1 : 0);
    end
    check("R10 hold dropped", hold_req, 0);
    check("R9 flag set", status[1], 1);
    cycles(4);
    check("R9 flag sticky", status[1], 1);
    read_status();
    check("R9 flag cleared by read", status[1], 0);
    dreq = '0;
    cycles(3);
  endtask

  task automatic t_order(bit rot);
    int exp_f [8] = '{0, 0, 1, 1, 2, 2, 3, 3};
    int exp_r [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    for (int c = 0; c < 4; c++) write_reg(c, 1);
    write_reg(4, rot ? 16'h001f : 16'h000f);
    log_n = 0;
    dreq = 4'hf;
    wait_log(8);
    wait_idle();
    check(rot ? "R5 transfer total" : "R4 transfer total", log_n, 8);
    for (int i = 0; i < 8; i++)
      check(rot ? "R5 rotating order" : "R4 fixed order", log_ch[i],
            rot ? exp_r[i] : exp_f[i]);
    check("R10 idle after all done", hold_req, 0);
    read_status();
    dreq = '0;
    cycles(3);
  endtask

  task automatic t_mark();
    int marks = 0, tcs = 0, mark_at = -1;
    write_reg(3, 199);
    write_reg(4, 16'h0008);
    log_n = 0;
    dreq = 4'b1000;
    wait_log(200);
    wait_idle();
    check("R7 transfers for N=199", log_n, 200);
    for (int i = 0; i < log_n; i++) begin
      if (log_mk[i]) begin marks++; mark_at = i; end
      if (log_tc[i]) tcs++;
    end
    check("R8 mark count", marks, 1);
    check("R8 mark on 128th", mark_at, 127);
    check("R7 single tc", tcs, 1);
    check("R7 tc on 200th", log_tc[199], 1);
    dreq = '0;
    read_status();
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_hold_count();
    t_order(1'b0);
    t_order(1'b1);
    t_mark();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule